// File: doc/BRIEF.md
# Three-Dimensional DMA Address Generator

This block turns one transfer descriptor into a stream of copy commands for a separate data-mover engine. A transfer is a block made of frames, and each frame is made of arrays of a fixed byte length. The generator keeps a live source address, a live destination address and the remaining array and frame counts. It steps through the three dimensions with signed per-side strides. Either side can be pinned to a constant address so that a peripheral FIFO can be read or written repeatedly.

Software loads a descriptor with a one-cycle `load` strobe and then raises synchronization events. In array-synchronized mode each event releases one command. In frame-synchronized mode each event releases one command per array of the current frame, issued back to back. Commands leave through a valid/ready handshake. After the last array of the last frame has been accepted, the block pulses `done` and goes quiet until the next descriptor is loaded.

Top module: `dma3d_addr_gen`

## Requirements
- R1: After reset, `cmd_valid` and `done` are low, and no command is issued until a descriptor is loaded.
- R2: Synchronization events seen before any descriptor has been loaded are ignored. A `load` on its own emits nothing.
- R3: In array-synchronized mode (`cfg_ab_sync`=0), each accepted event produces exactly one command. Its `cmd_bytes` equals the array byte count (bits 15:0 of `cfg_cnt`). `cmd_valid` is low in the cycle after that command is accepted.
- R4: In frame-synchronized mode (`cfg_ab_sync`=1), each accepted event produces the commands for every array of one frame, back to back. There is no gap beyond the handshake. `cmd_valid` falls after the last of them.
- R5: Within a frame, each non-constant side moves by its signed 16-bit array stride. The source stride sits in bits 15:0 of `cfg_bidx` and the destination stride in bits 31:16. Address arithmetic wraps modulo 2^AW.
- R6: At a frame boundary, each non-constant side adds its signed frame stride. The source stride is in `cfg_cidx` bits 15:0 and the destination stride in bits 31:16. In frame-synchronized mode the stride is added to the start address of the frame just finished. In array-synchronized mode it is added to the address of that frame's last array.
- R7: The first frame holds `cfg_cnt` bits 31:16 arrays. In array-synchronized mode each later frame holds `cfg_bcnt_rld` arrays. In frame-synchronized mode each later frame holds the loaded frame size again. The block holds `cfg_ccnt` frames.
- R8: A side flagged constant (`cfg_src_fifo` / `cfg_dst_fifo`) keeps its loaded address for every command. The two flags and the 3-bit `cfg_fifo_w` are reported unchanged on every command.
- R9: While `cmd_valid` is high and `cmd_ready` is low, all command fields hold their values.
- R10: `done` is high for exactly one cycle, in the cycle after the final command is accepted. Events after that are ignored until the next `load`.
- R11: Synchronization events that arrive while a command is pending are dropped and not queued.
- R12: With all strides zero, every command of the transfer carries the same source and destination address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | One-cycle strobe that captures the descriptor |
| cfg_src | input | AW | Initial source address |
| cfg_dst | input | AW | Initial destination address |
| cfg_cnt | input | 2*CW | Array byte count [15:0], arrays per frame [31:16] |
| cfg_ccnt | input | CW | Frames per block |
| cfg_bidx | input | 2*IW | Array strides: source [15:0], destination [31:16] |
| cfg_cidx | input | 2*IW | Frame strides: source [15:0], destination [31:16] |
| cfg_bcnt_rld | input | CW | Arrays per frame after the first (array-sync mode) |
| cfg_ab_sync | input | 1 | 1 = one frame per event, 0 = one array per event |
| cfg_src_fifo | input | 1 | Source address held constant |
| cfg_dst_fifo | input | 1 | Destination address held constant |
| cfg_fifo_w | input | 3 | Access width code for constant-address sides |
| sync_evt | input | 1 | Synchronization event |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_src | output | AW | Command source address |
| cmd_dst | output | AW | Command destination address |
| cmd_bytes | output | CW | Command byte count |
| cmd_src_fifo | output | 1 | Source side is constant-address |
| cmd_dst_fifo | output | 1 | Destination side is constant-address |
| cmd_fifo_w | output | 3 | Constant-address access width code |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps both sync modes over every combination of small frame sizes, block lengths, reload sizes and constant-side selections, with mixed-sign strides and periodic back-pressure. In array-synchronized mode, a generator that added the frame stride to the frame start instead of the last array address shows up once a frame holds more than one array. A generator that ignored the reload value does the same from the second frame on. Events are injected during every handshake. A design that queued them would raise `cmd_valid` without a fresh event, and one that left `done` up, or re-armed after completion, is caught by the quiet-window checks. A negative stride wrapping through address zero, and an all-zero-stride transfer, check sign extension and repeated access to one location.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EMIT = 2'd2
  } d3_state_e;

  localparam int D3_FW_BITS = 3;
  localparam int D3_SIDES   = 2;
  localparam int D3_SRC     = 0;
  localparam int D3_DST     = 1;

endpackage

// File: rtl/dma3d_side.sv
module dma3d_side #(
  parameter int AW = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] init_addr,
  input  logic [IW-1:0] arr_idx,
  input  logic [IW-1:0] frm_idx,
  input  logic          fixed,
  input  logic          ab_mode,
  input  logic          step,
  input  logic          frame_end,
  output logic [AW-1:0] addr
);

  localparam int EXT = AW - IW;

  function automatic logic [AW-1:0] add_stride(input logic [AW-1:0] base,
                                               input logic [IW-1:0] idx);
    return base + {{EXT{idx[IW-1]}}, idx};
  endfunction

  logic [AW-1:0] cur_q;
  logic [AW-1:0] fstart_q;
  logic [AW-1:0] next_frame;

  assign next_frame = ab_mode ? add_stride(fstart_q, frm_idx)
                              : add_stride(cur_q, frm_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= '0;
      fstart_q <= '0;
    end else if (load) begin
      cur_q    <= init_addr;
      fstart_q <= init_addr;
    end else if (step && !fixed) begin
      if (frame_end) begin
        cur_q    <= next_frame;
        fstart_q <= next_frame;
      end else begin
        cur_q <= add_stride(cur_q, arr_idx);
      end
    end
  end

  assign addr = cur_q;

endmodule

// File: rtl/dma3d_counts.sv
module dma3d_counts #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] bcnt_init,
  input  logic [CW-1:0] ccnt_init,
  input  logic [CW-1:0] bcnt_keep,
  input  logic [CW-1:0] bcnt_rld,
  input  logic          ab_mode,
  input  logic          step,
  output logic          frame_end,
  output logic          block_end
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] bleft_q;
  logic [CW-1:0] cleft_q;

  assign frame_end = (bleft_q == ONE);
  assign block_end = (cleft_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bleft_q <= '0;
      cleft_q <= '0;
    end else if (load) begin
      bleft_q <= bcnt_init;
      cleft_q <= ccnt_init;
    end else if (step) begin
      if (frame_end) begin
        if (!block_end) begin
          cleft_q <= cleft_q - ONE;
          bleft_q <= ab_mode ? bcnt_keep : bcnt_rld;
        end
      end else begin
        bleft_q <= bleft_q - ONE;
      end
    end
  end

endmodule

// File: rtl/dma3d_addr_gen.sv
module dma3d_addr_gen
  import dma3d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int IW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [AW-1:0]   cfg_src,
  input  logic [AW-1:0]   cfg_dst,
  input  logic [2*CW-1:0] cfg_cnt,
  input  logic [CW-1:0]   cfg_ccnt,
  input  logic [2*IW-1:0] cfg_bidx,
  input  logic [2*IW-1:0] cfg_cidx,
  input  logic [CW-1:0]   cfg_bcnt_rld,
  input  logic            cfg_ab_sync,
  input  logic            cfg_src_fifo,
  input  logic            cfg_dst_fifo,
  input  logic [2:0]      cfg_fifo_w,
  input  logic            sync_evt,
  output logic            cmd_valid,
  input  logic            cmd_ready,
  output logic [AW-1:0]   cmd_src,
  output logic [AW-1:0]   cmd_dst,
  output logic [CW-1:0]   cmd_bytes,
  output logic            cmd_src_fifo,
  output logic            cmd_dst_fifo,
  output logic [2:0]      cmd_fifo_w,
  output logic            done
);

  // registered descriptor
  logic          ab_q, sfix_q, dfix_q;
  logic [2:0]    fw_q;
  logic [CW-1:0] acnt_q, bcnt_q, rld_q;
  logic [2*IW-1:0] bidx_q, cidx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_q   <= 1'b0;
      sfix_q <= 1'b0;
      dfix_q <= 1'b0;
      fw_q   <= '0;
      acnt_q <= '0;
      bcnt_q <= '0;
      rld_q  <= '0;
      bidx_q <= '0;
      cidx_q <= '0;
    end else if (load) begin
      ab_q   <= cfg_ab_sync;
      sfix_q <= cfg_src_fifo;
      dfix_q <= cfg_dst_fifo;
      fw_q   <= cfg_fifo_w;
      acnt_q <= cfg_cnt[CW-1:0];
      bcnt_q <= cfg_cnt[2*CW-1:CW];
      rld_q  <= cfg_bcnt_rld;
      bidx_q <= cfg_bidx;
      cidx_q <= cfg_cidx;
    end
  end

  // named internal events
  d3_state_e st_q;
  logic step, frame_end, block_end, final_step, chunk_end, ev_take, st_idle;

  assign cmd_valid  = (st_q == ST_EMIT);
  assign step       = cmd_valid && cmd_ready;
  assign final_step = step && frame_end && block_end;
  assign chunk_end  = ab_q ? frame_end : 1'b1;
  assign ev_take    = (st_q == ST_WAIT) && sync_evt;
  assign st_idle    = (st_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      done <= 1'b0;
    end else begin
      done <= final_step && !load;
      if (load) begin
        st_q <= ST_WAIT;
      end else begin
        unique case (st_q)
          ST_WAIT: if (ev_take) st_q <= ST_EMIT;
          ST_EMIT: begin
            if (final_step)               st_q <= ST_IDLE;
            else if (step && chunk_end)   st_q <= ST_WAIT;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  dma3d_counts #(.CW(CW)) u_counts (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .bcnt_init (cfg_cnt[2*CW-1:CW]),
    .ccnt_init (cfg_ccnt),
    .bcnt_keep (bcnt_q),
    .bcnt_rld  (rld_q),
    .ab_mode   (ab_q),
    .step      (step),
    .frame_end (frame_end),
    .block_end (block_end)
  );

  // source and destination walkers
  logic [D3_SIDES-1:0][AW-1:0] init_a, addr_a;
  logic [D3_SIDES-1:0][IW-1:0] bidx_a, cidx_a;
  logic [D3_SIDES-1:0]         fix_a;

  assign init_a[D3_SRC] = cfg_src;
  assign init_a[D3_DST] = cfg_dst;
  assign fix_a[D3_SRC]  = sfix_q;
  assign fix_a[D3_DST]  = dfix_q;

  for (genvar g = 0; g < D3_SIDES; g++) begin : g_side
    assign bidx_a[g] = bidx_q[g*IW +: IW];
    assign cidx_a[g] = cidx_q[g*IW +: IW];
    dma3d_side #(.AW(AW), .IW(IW)) u_side (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .init_addr (init_a[g]),
      .arr_idx   (bidx_a[g]),
      .frm_idx   (cidx_a[g]),
      .fixed     (fix_a[g]),
      .ab_mode   (ab_q),
      .step      (step),
      .frame_end (frame_end),
      .addr      (addr_a[g])
    );
  end

  assign cmd_src      = addr_a[D3_SRC];
  assign cmd_dst      = addr_a[D3_DST];
  assign cmd_bytes    = acnt_q;
  assign cmd_src_fifo = sfix_q;
  assign cmd_dst_fifo = dfix_q;
  assign cmd_fifo_w   = fw_q;

endmodule

// File: rtl/dma3d_checker.sv
module dma3d_checker #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [AW-1:0] cmd_src,
  input logic [AW-1:0] cmd_dst,
  input logic [CW-1:0] cmd_bytes,
  input logic          done,
  input logic          step,
  input logic          final_step,
  input logic          chunk_end,
  input logic          ab_mode,
  input logic          src_fixed,
  input logic          dst_fixed,
  input logic          st_idle
);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready && !load |=> cmd_valid && $stable(cmd_src)
      && $stable(cmd_dst) && $stable(cmd_bytes));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_follows_final_R10: assert property (@(posedge clk) disable iff (!rst_n)
    final_step && !load |=> done && !cmd_valid);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle && !load |=> !cmd_valid);

  assert_one_array_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step && !ab_mode && !load |=> !cmd_valid);

  assert_burst_continues_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step && ab_mode && !chunk_end && !load |=> cmd_valid);

  assert_src_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step && src_fixed && !load |=> cmd_src == $past(cmd_src));

  assert_dst_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step && dst_fixed && !load |=> cmd_dst == $past(cmd_dst));

endmodule

bind dma3d_addr_gen dma3d_checker #(.AW(AW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load       (load),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_src    (cmd_src),
  .cmd_dst    (cmd_dst),
  .cmd_bytes  (cmd_bytes),
  .done       (done),
  .step       (step),
  .final_step (final_step),
  .chunk_end  (chunk_end),
  .ab_mode    (ab_q),
  .src_fixed  (sfix_q),
  .dst_fixed  (dfix_q),
  .st_idle    (st_idle)
);

// File: tb/dma3d_addr_gen_tb.sv
`timescale 1ns/1ps
module dma3d_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [31:0] cfg_src = '0, cfg_dst = '0, cfg_cnt = '0, cfg_bidx = '0, cfg_cidx = '0;
  logic [15:0] cfg_ccnt = '0, cfg_bcnt_rld = '0;
  logic        cfg_ab_sync = 1'b0, cfg_src_fifo = 1'b0, cfg_dst_fifo = 1'b0;
  logic [2:0]  cfg_fifo_w = '0;
  logic        sync_evt = 1'b0;
  logic        cmd_ready = 1'b0;
  logic        cmd_valid, cmd_src_fifo, cmd_dst_fifo, done;
  logic [31:0] cmd_src, cmd_dst;
  logic [15:0] cmd_bytes;
  logic [2:0]  cmd_fifo_w;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int stall_ctr = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma3d_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .load(load),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt), .cfg_ccnt(cfg_ccnt),
    .cfg_bidx(cfg_bidx), .cfg_cidx(cfg_cidx), .cfg_bcnt_rld(cfg_bcnt_rld),
    .cfg_ab_sync(cfg_ab_sync), .cfg_src_fifo(cfg_src_fifo), .cfg_dst_fifo(cfg_dst_fifo),
    .cfg_fifo_w(cfg_fifo_w), .sync_evt(sync_evt), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_bytes(cmd_bytes),
    .cmd_src_fifo(cmd_src_fifo), .cmd_dst_fifo(cmd_dst_fifo), .cmd_fifo_w(cmd_fifo_w),
    .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    wait (cyc >= 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1..all actual=%0d expected=<150000", cyc);
    summary();
    $finish;
  end

  task automatic take_cmd(input logic [31:0] es, input logic [31:0] ed, input int acnt,
                          input bit sf, input bit df, input logic [2:0] fw, input bit inj,
                          input bit last_chunk, input bit fin, input bit ab);
    bit got = 1'b0;
    int t = 0;
    while (!got && t < 8) begin
      chk(cmd_valid, ab ? "R4 command present" : "R3 command present", cmd_valid, 1);
      if (!cmd_valid) break;
      chk(cmd_src == es, "R5 R6 R9 R12 source address", cmd_src, es);
      chk(cmd_dst == ed, "R5 R6 R9 R12 destination address", cmd_dst, ed);
      chk(cmd_bytes == 16'(acnt), "R3 byte count", cmd_bytes, acnt);
      chk({cmd_src_fifo, cmd_dst_fifo, cmd_fifo_w} == {sf, df, fw}, "R8 fifo flags",
          {cmd_src_fifo, cmd_dst_fifo, cmd_fifo_w}, {sf, df, fw});
      stall_ctr++;
      if (stall_ctr % 3 == 2) cmd_ready = 1'b0;
      else begin
        cmd_ready = 1'b1;
        got = 1'b1;
        sync_evt = inj;
      end
      @(negedge clk);
      cmd_ready = 1'b0;
      sync_evt = 1'b0;
      t++;
    end
    if (fin) begin
      chk(done, "R10 done after final accept", done, 1);
      chk(!cmd_valid, "R10 no command after final", cmd_valid, 0);
      @(negedge clk);
      chk(!done, "R10 done lasts one cycle", done, 0);
    end else begin
      chk(!done, "R10 no early done", done, 0);
      if (last_chunk) begin
        chk(!cmd_valid, ab ? "R4 burst ends at frame end" : "R3 one array per event",
            cmd_valid, 0);
        if (inj) begin
          @(negedge clk);
          chk(!cmd_valid, "R11 event during pending command dropped", cmd_valid, 0);
        end
      end
    end
  endtask

  task automatic run_case(input bit ab, input bit sf, input bit df, input int acnt,
                          input int bcnt, input int ccnt, input int rld, input int sb,
                          input int db, input int sc, input int dc, input logic [31:0] s0,
                          input logic [31:0] d0, input logic [2:0] fw);
    logic [31:0] fs_s = s0;
    logic [31:0] fs_d = d0;
    logic [31:0] es, ed;
    int nb;
    cfg_src = s0;
    cfg_dst = d0;
    cfg_cnt = {16'(bcnt), 16'(acnt)};
    cfg_ccnt = 16'(ccnt);
    cfg_bidx = {16'(db), 16'(sb)};
    cfg_cidx = {16'(dc), 16'(sc)};
    cfg_bcnt_rld = 16'(rld);
    cfg_ab_sync = ab;
    cfg_src_fifo = sf;
    cfg_dst_fifo = df;
    cfg_fifo_w = fw;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk(!cmd_valid && !done, "R2 load alone emits nothing", {cmd_valid, done}, 0);
    for (int j = 0; j < ccnt; j++) begin
      nb = (ab || j == 0) ? bcnt : rld;
      for (int k = 0; k < nb; k++) begin
        es = sf ? s0 : 32'(fs_s + 32'(k * sb));
        ed = df ? d0 : 32'(fs_d + 32'(k * db));
        if (!ab || k == 0) begin
          sync_evt = 1'b1;
          @(negedge clk);
          sync_evt = 1'b0;
        end
        take_cmd(es, ed, acnt, sf, df, fw, k == 0, ab ? (k == nb - 1) : 1'b1,
                 (j == ccnt - 1) && (k == nb - 1), ab);
      end
      if (ab) begin
        fs_s = 32'(fs_s + 32'(sc));
        fs_d = 32'(fs_d + 32'(dc));
      end else begin
        fs_s = 32'(fs_s + 32'((nb - 1) * sb + sc));
        fs_d = 32'(fs_d + 32'((nb - 1) * db + dc));
      end
    end
    sync_evt = 1'b1;
    @(negedge clk);
    sync_evt = 1'b0;
    for (int q = 0; q < 3; q++) begin
      chk(!cmd_valid, "R10 events after done ignored", cmd_valid, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    int cid = 0;
    repeat (3) @(negedge clk);
    chk(!cmd_valid, "R1 reset valid low", cmd_valid, 0);
    chk(!done, "R1 reset done low", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    sync_evt = 1'b1;
    @(negedge clk);
    sync_evt = 1'b0;
    for (int q = 0; q < 3; q++) begin
      chk(!cmd_valid, "R2 event before load ignored", cmd_valid, 0);
      chk(!done, "R1 no done before load", done, 0);
      @(negedge clk);
    end

    for (int ab = 0; ab < 2; ab++)
      for (int bc = 1; bc <= 3; bc++)
        for (int cc = 1; cc <= 3; cc++)
          for (int rl = 1; rl <= 2; rl++)
            for (int fx = 0; fx < 4; fx++) begin
              // R7 reload sizes and R6 frame strides swept here
              run_case(ab[0], fx[0], fx[1], 1 + cid % 37, bc, cc, rl,
                       (cid % 2 == 1 ? -1 : 1) * (4 + cid % 7),
                       (cid % 3 == 0 ? -1 : 1) * (16 + cid % 5),
                       (cid % 4 < 2 ? -1 : 1) * (64 + cid % 9),
                       (cid % 5 == 0 ? -1 : 1) * (100 + cid % 11),
                       32'h1000_0000 + 32'(cid * 256), 32'h2000_0000 - 32'(cid * 128),
                       3'(cid % 8));
              cid++;
            end

    // R12 zero strides: repeated access to one location in both modes
    run_case(1'b0, 1'b0, 1'b0, 4, 3, 2, 3, 0, 0, 0, 0, 32'h4000_0040, 32'h5000_0080, 3'd2);
    run_case(1'b1, 1'b0, 1'b0, 4, 3, 2, 3, 0, 0, 0, 0, 32'h4000_0040, 32'h5000_0080, 3'd5);
    // R5 negative stride wrapping through address zero
    run_case(1'b1, 1'b0, 1'b0, 8, 3, 2, 1, -16, 32, -48, 7, 32'h0000_0010,
             32'hFFFF_FFF0, 3'd0);
    run_case(1'b0, 1'b0, 1'b0, 8, 3, 3, 2, -16, 32, -48, 7, 32'h0000_0010,
             32'hFFFF_FFF0, 3'd7);

    summary();
    $finish;
  end

endmodule